// File: doc/BRIEF.md
# Bidirectional latched bus transceiver

This block passes eight-bit data between two ports, A and B, in both directions at once. Each direction owns a storage element and three active-low controls: a chip enable, a latch enable and an output enable. The chip enable gates both sides of a direction. Loading the storage element needs the chip enable and the latch enable both low. Driving the far port needs the chip enable and the output enable both low. The B-to-A direction mirrors the A-to-B one, with its own three controls and its own storage.

For synthesis, each port is split into an input vector, an output vector and an output-enable flag, so that a wrapper higher up can place real three-state pads. The transparent latch is modelled with a sampling clock: while a direction is open, its storage reloads on every clock edge. A parameter selects one of two variants. In the default variant the output follows the input one clock later. In the other variant the open storage element is bypassed so that the output follows the input at once. A synchronous reset clears both storage elements and leaves the output-enable logic untouched. A flag reports any moment in which both directions drive at the same time, so that each port is being driven by the block while the other direction is also driving.

Top module: `latched_xcvr`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears both storage elements to zero, and reset wins over an open latch.
- R2: While a direction's chip enable and latch enable are both low, its storage loads the input of that direction on every rising clock edge. With output enable also low, the far output equals the input sampled at the previous edge.
- R3: When the latch enable goes high while the chip enable stays low, the storage keeps the value it loaded at the last edge at which it was open, whatever the input does afterwards.
- R4: When the chip enable goes high while the latch enable stays low, the storage also stops loading and keeps the value it loaded at the last open edge.
- R5: A direction's output-enable flag (`b_oe` for A-to-B, `a_oe` for B-to-A) is 1 exactly when that direction's chip enable and output enable are both low. It is combinational.
- R6: With chip enable low, latch enable high and output enable low, the output shows the stored value and not the current input.
- R7: The two directions are independent: the controls and input of one direction never change the storage or the outputs of the other.
- R8: `drive_clash` is 1 exactly when `a_oe` and `b_oe` are both 1.
- R9: While a direction's output-enable flag is 0, its output vector is all zeros.
- R10: Reset does not affect the output-enable flags: during reset they still follow R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ab_chip_en_n | input | 1 | A-to-B chip enable, active low |
| ab_latch_en_n | input | 1 | A-to-B latch enable, active low |
| ab_out_en_n | input | 1 | A-to-B output enable, active low |
| ba_chip_en_n | input | 1 | B-to-A chip enable, active low |
| ba_latch_en_n | input | 1 | B-to-A latch enable, active low |
| ba_out_en_n | input | 1 | B-to-A output enable, active low |
| a_i | input | WIDTH | Value seen on bus A |
| a_o | output | WIDTH | Value the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_i | input | WIDTH | Value seen on bus B |
| b_o | output | WIDTH | Value the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B |
| drive_clash | output | 1 | Both directions are driving at once |

## Verification
The bench targets the two ways transparency can end. In one, the latch enable rises while the chip enable is low. In the other, the chip enable rises while the latch enable is low. A design that decodes only the latch enable would keep loading in the second case and show new data. The bench also holds the latch enable high with outputs enabled and changes the input. A design that bypasses the storage there would leak the live input. It checks that reset clears storage even while a latch is open, and that the drive enables keep following their controls during reset. It runs both directions open together to catch any cross-wiring of controls or data between the two paths, and to confirm the clash flag.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   // How the output tracks an open storage element
   typedef enum logic {
      FOLLOW_SAMPLED = 1'b0,   // output lags the input by one clock
      FOLLOW_BYPASS  = 1'b1    // output follows the input combinationally
   } follow_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
   import xcvr_pkg::*;
#(
   parameter int      WIDTH = 8,
   parameter follow_e MODE  = FOLLOW_SAMPLED
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             open_i,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] q_o
);
   localparam logic [WIDTH-1:0] CLEAR = '0;

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_store: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] held;

   always_ff @(posedge clk) begin
      if (rst)         held <= CLEAR;
      else if (open_i) held <= din_i;
   end

   if (MODE == FOLLOW_BYPASS) begin : g_bypass
      assign q_o = open_i ? din_i : held;
   end else begin : g_sampled
      assign q_o = held;
   end

   // R2: an open element picks up the input at the edge
   p_load_open_r2: assert property (@(posedge clk) disable iff (rst)
      open_i |=> (held == $past(din_i)));

   // R3 / R4: a closed element keeps its contents
   p_hold_closed_r3: assert property (@(posedge clk) disable iff (rst)
      !open_i |=> $stable(held));
endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
   import xcvr_pkg::*;
#(
   parameter int      WIDTH = 8,
   parameter follow_e MODE  = FOLLOW_SAMPLED
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             chip_en_n,
   input  logic             latch_en_n,
   input  logic             out_en_n,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] dout_o,
   output logic             drive_o
);
   localparam logic [WIDTH-1:0] IDLE_VAL = '0;

   logic             open_w;
   logic [WIDTH-1:0] stored_w;

   assign open_w  = ~chip_en_n & ~latch_en_n;
   assign drive_o = ~chip_en_n & ~out_en_n;

   xcvr_store #(.WIDTH(WIDTH), .MODE(MODE)) store_i (
      .clk    (clk),
      .rst    (rst),
      .open_i (open_w),
      .din_i  (din_i),
      .q_o    (stored_w)
   );

   assign dout_o = drive_o ? stored_w : IDLE_VAL;

   // R5: driving implies the chip enable is active
   p_drive_needs_ce_r5: assert property (@(posedge clk) disable iff (rst)
      drive_o |-> !chip_en_n);

   // R9: an undriven output carries no data
   p_quiet_off_r9: assert property (@(posedge clk) disable iff (rst)
      !drive_o |-> (dout_o == IDLE_VAL));
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
   import xcvr_pkg::*;
#(
   parameter int      WIDTH = 8,
   parameter follow_e MODE  = FOLLOW_SAMPLED
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ab_chip_en_n,
   input  logic             ab_latch_en_n,
   input  logic             ab_out_en_n,
   input  logic             ba_chip_en_n,
   input  logic             ba_latch_en_n,
   input  logic             ba_out_en_n,
   input  logic [WIDTH-1:0] a_i,
   output logic [WIDTH-1:0] a_o,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] b_o,
   output logic             b_oe,
   output logic             drive_clash
);
   localparam int N_DIR = 2;

   if (WIDTH < 1 || WIDTH > 1024) begin : g_bad_width
      $error("latched_xcvr: WIDTH out of range");
   end

   logic [N_DIR-1:0]            ce_n_w, le_n_w, oe_n_w, drv_w;
   logic [N_DIR-1:0][WIDTH-1:0] din_w, dout_w;

   // index 0: A to B, index 1: B to A
   assign ce_n_w = {ba_chip_en_n,  ab_chip_en_n};
   assign le_n_w = {ba_latch_en_n, ab_latch_en_n};
   assign oe_n_w = {ba_out_en_n,   ab_out_en_n};
   assign din_w  = {b_i, a_i};

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      xcvr_dir_path #(.WIDTH(WIDTH), .MODE(MODE)) path_i (
         .clk        (clk),
         .rst        (rst),
         .chip_en_n  (ce_n_w[d]),
         .latch_en_n (le_n_w[d]),
         .out_en_n   (oe_n_w[d]),
         .din_i      (din_w[d]),
         .dout_o     (dout_w[d]),
         .drive_o    (drv_w[d])
      );
   end

   assign b_o         = dout_w[0];
   assign b_oe        = drv_w[0];
   assign a_o         = dout_w[1];
   assign a_oe        = drv_w[1];
   assign drive_clash = &drv_w;

   // R8: the clash flag never rises while one side is silent
   p_clash_both_r8: assert property (@(posedge clk) disable iff (rst)
      drive_clash |-> (a_oe && b_oe));

   // R7: B-to-A output is unaffected by A-side data when its controls are quiet
   p_ba_indep_r7: assert property (@(posedge clk) disable iff (rst)
      (ba_chip_en_n && $stable(ba_chip_en_n)) |-> (a_o == '0));
endmodule

// File: tb/latched_xcvr_tb_top.sv
module latched_xcvr_tb_top;
   logic       clk = 1'b0;
   logic       rst;
   logic       ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
   logic [7:0] a_i, b_i, a_o, b_o;
   logic       a_oe, b_oe, drive_clash;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   latched_xcvr dut_i (
      .clk(clk), .rst(rst),
      .ab_chip_en_n(ab_ce_n), .ab_latch_en_n(ab_le_n), .ab_out_en_n(ab_oe_n),
      .ba_chip_en_n(ba_ce_n), .ba_latch_en_n(ba_le_n), .ba_out_en_n(ba_oe_n),
      .a_i(a_i), .a_o(a_o), .a_oe(a_oe),
      .b_i(b_i), .b_o(b_o), .b_oe(b_oe),
      .drive_clash(drive_clash)
   );

   typedef struct packed {
      logic [2:0] ab_ctl;   // {ce_n, le_n, oe_n}
      logic [7:0] a_in;
      logic [2:0] ba_ctl;   // {ce_n, le_n, oe_n}
      logic [7:0] b_in;
      logic [7:0] exp_b;
      logic       exp_boe;
      logic [7:0] exp_a;
      logic       exp_aoe;
      logic       exp_clash;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      // R2 A-to-B transparent, B-to-A idle
      '{3'b000, 8'hA5, 3'b111, 8'h3C, 8'hA5, 1'b1, 8'h00, 1'b0, 1'b0},
      // R3/R6 LE rose: hold A5; B-to-A loads 3C, not driving
      '{3'b010, 8'h5A, 3'b001, 8'h3C, 8'hA5, 1'b1, 8'h00, 1'b0, 1'b0},
      // R9 A-to-B off; R6/R7 B-to-A shows stored 3C
      '{3'b011, 8'hFF, 3'b010, 8'h11, 8'h00, 1'b0, 8'h3C, 1'b1, 1'b0},
      // R2 reopen A-to-B; B-to-A CE high blocks load
      '{3'b000, 8'h0F, 3'b100, 8'h22, 8'h0F, 1'b1, 8'h00, 1'b0, 1'b0},
      // R4 CE rose with LE low: hold 0F, off
      '{3'b100, 8'hF0, 3'b010, 8'h22, 8'h00, 1'b0, 8'h3C, 1'b1, 1'b0},
      // R4 held value reappears; R8 both drive
      '{3'b010, 8'h99, 3'b010, 8'h77, 8'h0F, 1'b1, 8'h3C, 1'b1, 1'b1},
      // R7 both transparent together
      '{3'b000, 8'hC3, 3'b000, 8'h81, 8'hC3, 1'b1, 8'h81, 1'b1, 1'b1},
      // R9 everything off
      '{3'b111, 8'h00, 3'b111, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
      // R3 contents survive the off stretch
      '{3'b010, 8'h00, 3'b010, 8'h00, 8'hC3, 1'b1, 8'h81, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] ab, input logic [7:0] av,
                        input logic [2:0] ba, input logic [7:0] bv);
      {ab_ce_n, ab_le_n, ab_oe_n} = ab;
      {ba_ce_n, ba_le_n, ba_oe_n} = ba;
      a_i = av;
      b_i = bv;
   endtask

   initial begin
      rst = 1'b1;
      drive(3'b000, 8'hEE, 3'b000, 8'hDD);
      // R10: drive enables follow controls during reset
      #1;
      chk("R10 b_oe in reset", {7'd0, b_oe}, 8'd1);
      chk("R10 a_oe in reset", {7'd0, a_oe}, 8'd1);
      @(posedge clk); #1;
      // R1: reset wins over open latches
      chk("R1 b_o after reset", b_o, 8'h00);
      chk("R1 a_o after reset", a_o, 8'h00);
      @(negedge clk);
      rst = 1'b0;
      drive(3'b010, 8'hEE, 3'b010, 8'hDD);
      @(posedge clk); #1;
      chk("R1 b_o cleared hold", b_o, 8'h00);
      chk("R1 a_o cleared hold", a_o, 8'h00);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i].ab_ctl, VECS[i].a_in, VECS[i].ba_ctl, VECS[i].b_in);
         #1;
         // R5: combinational enables, visible before the edge
         chk("R5 b_oe", {7'd0, b_oe}, {7'd0, VECS[i].exp_boe});
         chk("R5 a_oe", {7'd0, a_oe}, {7'd0, VECS[i].exp_aoe});
         chk("R8 drive_clash", {7'd0, drive_clash}, {7'd0, VECS[i].exp_clash});
         @(posedge clk); #1;
         chk("R2/R3/R4/R6 b_o", b_o, VECS[i].exp_b);
         chk("R7/R9 a_o", a_o, VECS[i].exp_a);
      end

      // R6: live input change while held must not leak
      @(negedge clk);
      drive(3'b010, 8'h5A, 3'b010, 8'hA5);
      #1;
      chk("R6 b_o ignores live a_i", b_o, 8'hC3);
      @(posedge clk); #1;
      chk("R6 b_o still stored", b_o, 8'hC3);
      chk("R6 a_o still stored", a_o, 8'h81);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule